// File: doc/BRIEF.md
# Machine Control Sequencer

This block is the machine control unit of a small processor core. It carries out the carry-flag operations (set, clear, invert). It runs a wait operation that holds the core while an external, active-low busy line reports a busy coprocessor. It runs a halt state that can be left only by an interrupt, a reset or a DMA request. It drives an active-low bus lock pin for instructions that carry a lock prefix. It also runs an escape operation that hands a 6-bit opcode field to a coprocessor port.

The core presents one decoded operation per cycle on `op_valid`/`op_code`. It must keep presenting the same operation for as long as `stall` is high. An operation completes in the cycle in which it is presented and `stall` is low. Its register effects appear after the next rising clock edge. The busy line is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops (2 by default) before the wait logic uses it.

Top module: `mctl_seq`

## Requirements
- R1: Operation codes 1, 2 and 3 set, clear and invert the carry flag. The new value is visible one clock after the operation completes.
- R2: A wait operation (code 4) presented while the synchronized busy line is high completes at once: `stall` stays low and no carry or coprocessor output changes.
- R3: A wait operation presented while the synchronized busy line is low holds `stall` high. A rise of `busy_n` releases `stall` after exactly `SYNC_STAGES` rising edges.
- R4: A halt operation (code 5) raises `halted` and `stall` one clock after it completes. While halted, presented operations have no effect: the carry flag keeps its value.
- R5: While halted, `irq` high returns the block to running on the next clock, with `halted` and `stall` low. An interrupt has priority over a DMA request.
- R6: While halted, `dma_req` high moves the block to bus release (`dma_grant` high, `halted` low, `stall` high) on the next clock. `irq` is ignored in that state. When `dma_req` drops, the block returns to halt on the next clock.
- R7: Synchronous active-low reset clears the carry flag, leaves halt and bus release, sets `lock_n` high and clears `cop_strobe`. This holds from any state.
- R8: `lock_n` goes low in the same cycle in which a running core presents an operation with `lock_pfx` high. It is high while no locked operation has been presented since the last unlocked one.
- R9: After a locked operation completes, `lock_n` stays low through idle cycles (`op_valid` low) and through further locked operations. It rises in the same cycle that an unlocked operation is presented.
- R10: An interrupt taken while running (`irq` high in a cycle with `op_valid` low) releases a held lock: `lock_n` is high from the next clock.
- R11: An escape operation (code 6) produces a one-cycle `cop_strobe` pulse one clock after it completes, with `cop_opcode` equal to the `esc_field` presented with it. The carry flag is unchanged.
- R12: Code 0 (no operation) and codes 7 to 15 (other instructions) change neither the carry flag, nor `halted`, nor `cop_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Decoded operation code |
| lock_pfx | input | 1 | Presented operation carries the lock prefix |
| esc_field | input | 6 | Opcode field for the coprocessor, used with code 6 |
| busy_n | input | 1 | Asynchronous coprocessor busy line, low means busy |
| irq | input | 1 | Interrupt request |
| dma_req | input | 1 | DMA request |
| carry | output | 1 | Carry flag |
| stall | output | 1 | Core must hold the presented operation |
| halted | output | 1 | Block is in the halt state |
| dma_grant | output | 1 | Bus released to the DMA master while halted |
| lock_n | output | 1 | Bus lock pin, active low |
| cop_strobe | output | 1 | One-cycle coprocessor opcode strobe |
| cop_opcode | output | 6 | Opcode field passed to the coprocessor |

## Verification
A corrupted halt-state register shows on `stall` and `halted` in the same cycle. If the state wrongly sits in bus release, `dma_grant` rises instead, and the next presented operation makes no carry change one clock later. A stuck or missing lock-hold flop shows at `lock_n` in the first idle cycle after a locked operation, or one clock after an interrupt is taken. A wrong synchronizer depth moves the fall of `stall` by one clock relative to the rise of `busy_n`. A carry or strobe fault shows one clock after the operation that should have caused it. Every opcode is swept against both starting carry values.

// File: rtl/mctl_pkg.sv
// Package: shared encodings for the machine control sequencer.
// Assumes a 4-bit decoded operation code supplied by the core's decoder.
package mctl_pkg;

    localparam int OP_W  = 4;
    localparam int ESC_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_STC  = 4'd1,
        OP_CLC  = 4'd2,
        OP_CMC  = 4'd3,
        OP_WAIT = 4'd4,
        OP_HLT  = 4'd5,
        OP_ESC  = 4'd6
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_DMA  = 2'd2
    } run_state_e;

endpackage

// File: rtl/mctl_sync.sv
// Module: mctl_sync
// Multi-flop synchronizer for one asynchronous level input.
// Assumes STAGES >= 2. Reset loads RST_VAL into every stage.
module mctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/mctl_halt_fsm.sv
// Module: mctl_halt_fsm
// Run / halt / bus-release state machine.
// Assumes hlt_go is asserted only for a halt operation completing while running.
// In halt, an interrupt has priority over a DMA request. In bus release, the
// interrupt is ignored until the DMA request drops and halt resumes.
module mctl_halt_fsm
    import mctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hlt_go,
    input  logic irq,
    input  logic dma_req,
    output logic running,
    output logic halted,
    output logic dma_grant
);

    run_state_e state_q, state_d;

    // Next-state selection for the run / halt / bus-release cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (hlt_go) state_d = ST_HALT;
            ST_HALT: begin
                if (irq)          state_d = ST_RUN;
                else if (dma_req) state_d = ST_DMA;
            end
            ST_DMA:  if (!dma_req) state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    // State register; reset always resumes execution.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign running   = (state_q == ST_RUN);
    assign halted    = (state_q == ST_HALT);
    assign dma_grant = (state_q == ST_DMA);

    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !irq && !dma_req) |=> halted) else $error("halt left without cause"); // R4
    AST_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && irq) |=> running) else $error("irq did not leave halt"); // R5
    AST_DMA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_grant && !dma_req) |=> halted) else $error("no return to halt after dma"); // R6
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({running, halted, dma_grant})) else $error("state decode broken"); // R6

endmodule

// File: rtl/mctl_lock.sv
// Module: mctl_lock
// Active-low bus lock pin with hold across a run of locked operations.
// Assumes op_done marks completion of a presented operation and irq_take marks
// an interrupt accepted at an instruction boundary.
module mctl_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic op_valid,
    input  logic lock_pfx,
    input  logic op_done,
    input  logic irq_take,
    output logic lock_n
);

    logic hold_q;
    logic lock_now;

    assign lock_now = running && op_valid && lock_pfx;

    // Remember that the last completed operation was locked, until the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (!running || irq_take) begin
            hold_q <= 1'b0;
        end else if (op_done) begin
            hold_q <= lock_pfx;
        end
    end

    // The pin is released at once when an unlocked operation is presented.
    assign lock_n = !(lock_now || (hold_q && !(op_valid && !lock_pfx)));

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && lock_pfx && running) |=> (!lock_n || (op_valid && !lock_pfx) || !running))
        else $error("lock dropped inside run"); // R9
    AST_LOCK_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !op_valid) |=> (lock_n || op_valid)) else $error("lock kept after irq"); // R10
    AST_LOCK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !lock_pfx) |-> lock_n) else $error("lock low on unlocked op"); // R8

endmodule

// File: rtl/mctl_seq.sv
// Module: mctl_seq (top)
// Machine control sequencer: carry flag operations, wait on the busy line,
// halt with interrupt / DMA / reset exit, bus lock pin and coprocessor escape.
// Assumes the core holds a presented operation while stall is high.
module mctl_seq
    import mctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic             lock_pfx,
    input  logic [ESC_W-1:0] esc_field,
    input  logic             busy_n,
    input  logic             irq,
    input  logic             dma_req,
    output logic             carry,
    output logic             stall,
    output logic             halted,
    output logic             dma_grant,
    output logic             lock_n,
    output logic             cop_strobe,
    output logic [ESC_W-1:0] cop_opcode
);

    op_e  op;
    logic busy_ok;
    logic running;
    logic wait_block;
    logic op_done;
    logic irq_take;

    assign op = op_e'(op_code);

    mctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_busy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (busy_n),
        .q_sync  (busy_ok)
    );

    // Completion and stall decode for the presented operation.
    always_comb begin
        wait_block = running && op_valid && (op == OP_WAIT) && !busy_ok;
        op_done    = running && op_valid && !wait_block;
        irq_take   = running && !op_valid && irq;
        stall      = !running || wait_block;
    end

    mctl_halt_fsm i_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hlt_go    (op_done && (op == OP_HLT)),
        .irq       (irq),
        .dma_req   (dma_req),
        .running   (running),
        .halted    (halted),
        .dma_grant (dma_grant)
    );

    mctl_lock i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .op_valid (op_valid),
        .lock_pfx (lock_pfx),
        .op_done  (op_done),
        .irq_take (irq_take),
        .lock_n   (lock_n)
    );

    // Carry flag register updated by completed carry operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry <= 1'b0;
        end else if (op_done) begin
            case (op)
                OP_STC:  carry <= 1'b1;
                OP_CLC:  carry <= 1'b0;
                OP_CMC:  carry <= !carry;
                default: carry <= carry;
            endcase
        end
    end

    // Coprocessor strobe and opcode capture for a completed escape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cop_strobe <= 1'b0;
            cop_opcode <= '0;
        end else begin
            cop_strobe <= op_done && (op == OP_ESC);
            if (op_done && (op == OP_ESC)) cop_opcode <= esc_field;
        end
    end

    AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op == OP_STC) |=> carry) else $error("carry not set"); // R1
    AST_CMC_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op == OP_CMC) |=> (carry != $past(carry))) else $error("carry not inverted"); // R1
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_WAIT && !busy_ok && !halted && !dma_grant) |-> stall)
        else $error("wait passed while busy"); // R3
    AST_ESC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op == OP_ESC) |=> (cop_strobe && cop_opcode == $past(esc_field)))
        else $error("escape not passed"); // R11
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || dma_grant) |=> $stable(carry)) else $error("carry moved in halt"); // R4
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_code == 4'd0) |=> ($stable(carry) && !cop_strobe)) else $error("nop had effect"); // R12
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!carry && lock_n && !halted && !dma_grant && !cop_strobe))
        else $error("reset state wrong"); // R7

endmodule

// File: tb/test_mctl_seq.sv
// Bench for mctl_seq: opcode sweep against both carry values, then the wait,
// halt, DMA, reset and lock sequences. Inputs change 2 ns after a rising edge.
module test_mctl_seq;

    logic       clk = 1'b0;
    logic       rst_n, op_valid, lock_pfx, busy_n, irq, dma_req;
    logic [3:0] op_code;
    logic [5:0] esc_field;
    logic       carry, stall, halted, dma_grant, lock_n, cop_strobe;
    logic [5:0] cop_opcode;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mctl_seq i_mctl_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .lock_pfx(lock_pfx), .esc_field(esc_field), .busy_n(busy_n), .irq(irq),
        .dma_req(dma_req), .carry(carry), .stall(stall), .halted(halted),
        .dma_grant(dma_grant), .lock_n(lock_n), .cop_strobe(cop_strobe),
        .cop_opcode(cop_opcode)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic v, input logic [3:0] c, input logic lk, input logic [5:0] f);
        op_valid  = v;
        op_code   = c;
        lock_pfx  = lk;
        esc_field = f;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; busy_n = 1'b1; irq = 1'b0; dma_req = 1'b0;
        drive(1'b0, 4'd0, 1'b0, 6'd0);
        #2;
        tick(); tick(); tick();
        // R7: reset state
        chk({carry, halted, dma_grant, cop_strobe}, 8'h0, "R7 reset outputs");
        chk({lock_n, stall}, 8'h2, "R7 reset lock_n/stall");
        rst_n = 1'b1;
        tick();

        // Sweep of every opcode against both starting carry values (halt separately).
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                logic exp_c;
                logic [5:0] fld;
                if (op == 5) continue;
                drive(1'b1, (c != 0) ? 4'd1 : 4'd2, 1'b0, 6'd0);
                tick();
                fld = 6'((op * 4 + c * 2 + 1) & 63);
                drive(1'b1, 4'(op), 1'b0, fld);
                #1;
                chk({7'd0, stall}, 8'd0, (op == 4) ? "R2 wait no stall" : "R12 no stall");
                tick();
                drive(1'b0, 4'd0, 1'b0, 6'd0);
                case (op)
                    1: exp_c = 1'b1;
                    2: exp_c = 1'b0;
                    3: exp_c = (c == 0);
                    default: exp_c = (c != 0);
                endcase
                chk({7'd0, carry}, {7'd0, exp_c},
                    (op >= 1 && op <= 3) ? "R1 carry op" : ((op == 6) ? "R11 esc carry" : "R12 carry kept"));
                chk({7'd0, cop_strobe}, {7'd0, (op == 6)}, (op == 6) ? "R11 strobe" : "R12 no strobe");
                chk({7'd0, halted}, 8'd0, "R12 not halted");
                if (op == 6) begin
                    chk({2'd0, cop_opcode}, {2'd0, fld}, "R11 opcode field");
                    tick();
                    chk({7'd0, cop_strobe}, 8'd0, "R11 single pulse");
                end
            end
        end

        // R3: wait while busy, released after two synchronizer edges
        busy_n = 1'b0;
        tick(); tick(); tick();
        drive(1'b1, 4'd4, 1'b0, 6'd0);
        #1;
        chk({7'd0, stall}, 8'd1, "R3 wait stalls");
        tick(); tick();
        chk({7'd0, stall}, 8'd1, "R3 still stalled");
        busy_n = 1'b1;
        tick();
        chk({7'd0, stall}, 8'd1, "R3 one edge after release");
        tick();
        chk({7'd0, stall}, 8'd0, "R3 two edges after release");
        tick();
        drive(1'b0, 4'd0, 1'b0, 6'd0);

        // R4: halt, presented operation ignored
        drive(1'b1, 4'd2, 1'b0, 6'd0);
        tick();
        drive(1'b1, 4'd5, 1'b0, 6'd0);
        tick();
        chk({6'd0, halted, stall}, 8'h3, "R4 halted and stall");
        drive(1'b1, 4'd1, 1'b0, 6'd0);
        tick(); tick();
        chk({6'd0, carry, halted}, 8'h1, "R4 op ignored in halt");
        drive(1'b0, 4'd0, 1'b0, 6'd0);

        // R6: DMA exit and return
        dma_req = 1'b1;
        tick();
        chk({5'd0, dma_grant, halted, stall}, 8'h5, "R6 bus released");
        irq = 1'b1;
        tick();
        chk({6'd0, dma_grant, halted}, 8'h2, "R6 irq ignored in dma");
        irq = 1'b0; dma_req = 1'b0;
        tick();
        chk({6'd0, dma_grant, halted}, 8'h1, "R6 back to halt");

        // R5: interrupt exit, priority over DMA
        irq = 1'b1; dma_req = 1'b1;
        tick();
        chk({5'd0, halted, dma_grant, stall}, 8'h0, "R5 irq resumes");
        irq = 1'b0; dma_req = 1'b0;

        // R7: reset leaves halt and clears carry
        drive(1'b1, 4'd1, 1'b0, 6'd0);
        tick();
        drive(1'b1, 4'd5, 1'b0, 6'd0);
        tick();
        drive(1'b0, 4'd0, 1'b0, 6'd0);
        chk({6'd0, carry, halted}, 8'h3, "R7 setup halted carry");
        rst_n = 1'b0;
        tick();
        chk({6'd0, carry, halted}, 8'h0, "R7 reset from halt");
        rst_n = 1'b1;
        tick();

        // R8, R9: lock pin across a locked run with idle cycles
        drive(1'b1, 4'd7, 1'b0, 6'd0);
        #1;
        chk({7'd0, lock_n}, 8'd1, "R8 unlocked op");
        drive(1'b1, 4'd7, 1'b1, 6'd0);
        #1;
        chk({7'd0, lock_n}, 8'd0, "R8 locked op");
        tick();
        drive(1'b1, 4'd1, 1'b1, 6'd0);
        #1;
        chk({7'd0, lock_n}, 8'd0, "R9 second locked op");
        tick();
        drive(1'b0, 4'd0, 1'b0, 6'd0);
        #1;
        chk({7'd0, lock_n}, 8'd0, "R9 idle in run");
        tick();
        chk({7'd0, lock_n}, 8'd0, "R9 second idle");
        drive(1'b1, 4'd9, 1'b1, 6'd0);
        tick();
        drive(1'b1, 4'd9, 1'b0, 6'd0);
        #1;
        chk({7'd0, lock_n}, 8'd1, "R9 release on unlocked op");
        tick();
        drive(1'b0, 4'd0, 1'b0, 6'd0);

        // R10: interrupt taken between locked operations releases lock
        drive(1'b1, 4'd7, 1'b1, 6'd0);
        tick();
        drive(1'b0, 4'd0, 1'b0, 6'd0);
        irq = 1'b1;
        #1;
        chk({7'd0, lock_n}, 8'd0, "R10 held before irq edge");
        tick();
        irq = 1'b0;
        chk({7'd0, lock_n}, 8'd1, "R10 released after irq");
        tick();

        done = 1'b1;
        finish_run();
    end

endmodule